// File: doc/BRIEF.md
# Set-Associative Line Cache Controller

This block is a set-associative cache placed between a processor request port and a memory port that moves whole lines. Each stored line carries a valid flag, a dirty flag, a tag and its data. A 32-bit request address is cut into tag, set index and byte offset. The tag is compared against every way of the indexed set in the same cycle. Hits are served from the array. A miss picks a victim way. If that victim holds modified data, it is first written back, and the line is then fetched from memory.

Two build-time switches select the write behaviour. One makes every write also update memory, so lines never become dirty. The other decides whether a write miss fetches the line before modifying it, or instead sends only the written word to memory without filling anything. A single-cycle invalidate-all input drops every line. The processor port holds one request at a time: it stays not-ready from acceptance until the one-cycle response pulse has gone.

Top module: `sa_cache`

## Requirements
- R1: Offset width is log2(line bytes), index width is log2(lines / ways), and the tag takes the remaining bits of a 32-bit address. For 2048 lines, 4 ways and 16-byte lines this gives 4, 9 and 19 bits.
- R2: After reset, `req_ready_o` is 1, `rsp_valid_o` is 0 and `mem_req_o` is 0. Every line is invalid, so the first access to any address misses.
- R3: A read whose full tag matches a valid way of the indexed set is answered one cycle after acceptance with no memory traffic. The answer is the 32-bit word selected by address bits [OFFSET-1:2].
- R4: On a read miss, a victim way is chosen. If the victim is valid and dirty, it is first written to memory as one full-line write with all strobes set, at the address rebuilt from its tag and set. One line read follows, and the response carries the requested word of the fetched line.
- R5: The victim is the lowest-numbered invalid way of the set. If every way is valid, the victim is the way named by the set's rotating pointer, which then steps to the next way. Pointers start at way 0 on reset and are not changed by invalidate-all.
- R6: A write updates only the bytes whose `req_be_i` bit is set, where bit i selects bits [8i+7:8i] of the 32-bit word at address bits [OFFSET-1:2]. With write-through off, a write hit marks the line dirty and causes no memory traffic.
- R7: With write-through on, every write also causes exactly one memory write of that word, with strobes only on the written bytes. No line is ever dirty, and no write-back ever occurs.
- R8: With write-allocate on, a write miss fetches the line as in R4 and then merges the write into it. With it off, a write miss causes one memory word write and leaves the cache contents unchanged.
- R9: After a request is accepted, `req_ready_o` stays 0 until the cycle after the response. `rsp_valid_o` is a one-cycle pulse per request.
- R10: `flush_i` asserted while idle clears every valid and dirty flag without any write-back. `req_ready_o` is 0 in that cycle.
- R11: Once `mem_req_o` is raised, it stays high with stable address, direction and data until the cycle in which `mem_gnt_i` is 1. Read data is taken in the cycle `mem_rvalid_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines (acted on when idle) |
| req_valid_i | input | 1 | Processor request present |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Write word |
| req_be_i | input | 4 | Byte enables of the write word |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | 32 | Read word (0 for writes) |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = line write, 0 = line read |
| mem_addr_o | output | 32 | Line-aligned memory address |
| mem_wdata_o | output | LINE_BYTES*8 | Line write data |
| mem_wstrb_o | output | LINE_BYTES | Byte strobes of the line write |
| mem_gnt_i | input | 1 | Memory accepts the pending transfer |
| mem_rvalid_i | input | 1 | Line read data valid |
| mem_rdata_i | input | LINE_BYTES*8 | Line read data |

## Verification
The assertions assume that the memory side grants only a raised request, and that it returns exactly one `mem_rvalid_i` pulse after each granted read. They also assume `flush_i` is raised only while the cache is idle. The bench memory model grants one cycle after a request and returns read data one cycle after the grant. Invalidate-all is driven only between requests, after the previous response has been seen. Random addresses include high-bit aliases of the same memory line, so tag compares over the whole tag width are exercised together with the eviction and write-back paths.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_MEM_WR
  } cache_state_e;

  function automatic int off_bits(input int line_bytes);
    return $clog2(line_bytes);
  endfunction

  function automatic int idx_bits(input int lines, input int ways);
    return $clog2(lines / ways);
  endfunction

  function automatic int tag_bits(input int addr_w, input int lines, input int ways,
                                  input int line_bytes);
    return addr_w - idx_bits(lines, ways) - off_bits(line_bytes);
  endfunction

endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26
) (
  input  logic [WAYS-1:0]         valid_i,
  input  logic [WAYS*TAG_W-1:0]   tags_i,
  input  logic [TAG_W-1:0]        tag_i,
  output logic [WAYS-1:0]         match_o,
  output logic                    hit_o,
  output logic [$clog2(WAYS)-1:0] way_o
);
  localparam int WAY_W = $clog2(WAYS);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = valid_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
  end

  assign hit_o = |match_o;

  // OR-encode; match_o is one-hot by allocation rule
  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (match_o[w]) way_o = way_o | WAY_W'(w);
  end

endmodule

// File: rtl/cache_victim.sv
module cache_victim #(
  parameter int WAYS = 4,
  parameter int SETS = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [$clog2(SETS)-1:0] set_i,
  input  logic [WAYS-1:0]         valid_i,
  input  logic                    adv_i,
  output logic [$clog2(WAYS)-1:0] way_o
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] rr_q [SETS];
  logic             any_free;

  always_comb begin
    way_o    = rr_q[set_i];
    any_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        way_o    = WAY_W'(w);
        any_free = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (adv_i && !any_free) begin
      rr_q[set_i] <= rr_q[set_i] + WAY_W'(1);
    end
  end

  // R5
  rr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !any_free) |=> (rr_q[$past(set_i)] == $past(way_o) + WAY_W'(1)));

  // R5
  free_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_free |-> !valid_i[way_o]);

endmodule

// File: rtl/cache_merge.sv
module cache_merge #(
  parameter int LINE_BYTES = 16
) (
  input  logic [LINE_BYTES*8-1:0]          line_i,
  input  logic [$clog2(LINE_BYTES/4)-1:0]  wsel_i,
  input  logic [31:0]                      wdata_i,
  input  logic [3:0]                       be_i,
  output logic [LINE_BYTES*8-1:0]          line_o,
  output logic [LINE_BYTES-1:0]            strb_o
);
  localparam int WORDS  = LINE_BYTES / 4;
  localparam int WSEL_W = $clog2(WORDS);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_byte
      assign strb_o[w*4+b] = (wsel_i == WSEL_W'(w)) && be_i[b];
      assign line_o[(w*4+b)*8 +: 8] = strb_o[w*4+b] ? wdata_i[b*8 +: 8]
                                                    : line_i[(w*4+b)*8 +: 8];
    end
  end

endmodule

// File: rtl/sa_cache.sv
module sa_cache #(
  parameter int LINES         = 16,
  parameter int WAYS          = 4,
  parameter int LINE_BYTES    = 16,
  parameter bit WRITE_THROUGH = 1'b0,
  parameter bit WRITE_ALLOC   = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    req_valid_i,
  input  logic                    req_we_i,
  input  logic [31:0]             req_addr_i,
  input  logic [31:0]             req_wdata_i,
  input  logic [3:0]              req_be_i,
  output logic                    req_ready_o,
  output logic                    rsp_valid_o,
  output logic [31:0]             rsp_rdata_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [31:0]             mem_addr_o,
  output logic [LINE_BYTES*8-1:0] mem_wdata_o,
  output logic [LINE_BYTES-1:0]   mem_wstrb_o,
  input  logic                    mem_gnt_i,
  input  logic                    mem_rvalid_i,
  input  logic [LINE_BYTES*8-1:0] mem_rdata_i
);
  import cache_pkg::*;

  localparam int SETS   = LINES / WAYS;
  localparam int OFF_W  = off_bits(LINE_BYTES);
  localparam int IDX_W  = idx_bits(LINES, WAYS);
  localparam int TAG_W  = tag_bits(32, LINES, WAYS, LINE_BYTES);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WORDS  = LINE_BYTES / 4;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int WAY_W  = $clog2(WAYS);

  cache_state_e state_q;

  logic [LINE_W-1:0] data_q  [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];

  logic        rq_we_q;
  logic [31:0] rq_addr_q, rq_wdata_q;
  logic [3:0]  rq_be_q;
  logic [WAY_W-1:0] vway_q;
  logic        rsp_valid_q;
  logic [31:0] rsp_rdata_q;

  // request view: live ports while idle, latched copy otherwise
  logic              idle, accept;
  logic              cur_we;
  logic [31:0]       cur_addr, cur_wdata;
  logic [3:0]        cur_be;
  logic [TAG_W-1:0]  cur_tag;
  logic [IDX_W-1:0]  cur_set;
  logic [WSEL_W-1:0] cur_wsel;

  assign idle      = (state_q == ST_IDLE);
  assign cur_we    = idle ? req_we_i    : rq_we_q;
  assign cur_addr  = idle ? req_addr_i  : rq_addr_q;
  assign cur_wdata = idle ? req_wdata_i : rq_wdata_q;
  assign cur_be    = idle ? req_be_i    : rq_be_q;
  assign cur_tag   = cur_addr[31 -: TAG_W];
  assign cur_set   = cur_addr[OFF_W +: IDX_W];
  assign cur_wsel  = cur_addr[2 +: WSEL_W];

  logic unused_lo;
  assign unused_lo = ^cur_addr[1:0];

  assign req_ready_o = idle && !rsp_valid_q && !flush_i;
  assign accept      = req_valid_i && req_ready_o;

  // lookup
  logic [WAYS*TAG_W-1:0] set_tags;
  logic [WAYS-1:0]       match_vec;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way, vic_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_tags
    assign set_tags[w*TAG_W +: TAG_W] = tag_q[cur_set][w];
  end

  cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .valid_i (valid_q[cur_set]),
    .tags_i  (set_tags),
    .tag_i   (cur_tag),
    .match_o (match_vec),
    .hit_o   (hit),
    .way_o   (hit_way)
  );

  cache_victim #(.WAYS(WAYS), .SETS(SETS)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (cur_set),
    .valid_i (valid_q[cur_set]),
    .adv_i   (accept && !hit && (!req_we_i || WRITE_ALLOC)),
    .way_o   (vic_way)
  );

  // merge source: stored line on hit, fetched line on refill
  logic [LINE_W-1:0]     merge_src, merged;
  logic [LINE_BYTES-1:0] word_strb;
  logic [31:0]           rd_word;

  assign merge_src = (state_q == ST_FILL_WAIT) ? mem_rdata_i : data_q[cur_set][hit_way];
  assign rd_word   = merge_src[cur_wsel*32 +: 32];

  cache_merge #(.LINE_BYTES(LINE_BYTES)) u_merge (
    .line_i  (merge_src),
    .wsel_i  (cur_wsel),
    .wdata_i (cur_wdata),
    .be_i    (cur_be),
    .line_o  (merged),
    .strb_o  (word_strb)
  );

  // array write port
  logic             fill_done, data_we;
  logic [WAY_W-1:0] data_way;

  assign fill_done = (state_q == ST_FILL_WAIT) && mem_rvalid_i;
  assign data_we   = (accept && hit && req_we_i) || fill_done;
  assign data_way  = fill_done ? vway_q : hit_way;

  always_ff @(posedge clk_i) begin
    if (data_we) data_q[cur_set][data_way] <= cur_we ? merged : merge_src;
    if (fill_done) tag_q[cur_set][vway_q] <= cur_tag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rq_we_q     <= 1'b0;
      rq_addr_q   <= '0;
      rq_wdata_q  <= '0;
      rq_be_q     <= '0;
      vway_q      <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (flush_i) begin
            for (int s = 0; s < SETS; s++) begin
              valid_q[s] <= '0;
              dirty_q[s] <= '0;
            end
          end else if (accept) begin
            rq_we_q    <= req_we_i;
            rq_addr_q  <= req_addr_i;
            rq_wdata_q <= req_wdata_i;
            rq_be_q    <= req_be_i;
            vway_q     <= hit ? hit_way : vic_way;
            if (hit) begin
              if (!req_we_i) begin
                rsp_valid_q <= 1'b1;
                rsp_rdata_q <= rd_word;
              end else if (WRITE_THROUGH) begin
                state_q <= ST_MEM_WR;
              end else begin
                dirty_q[cur_set][hit_way] <= 1'b1;
                rsp_valid_q <= 1'b1;
                rsp_rdata_q <= '0;
              end
            end else if (req_we_i && !WRITE_ALLOC) begin
              state_q <= ST_MEM_WR;
            end else if (valid_q[cur_set][vic_way] && dirty_q[cur_set][vic_way]) begin
              state_q <= ST_WB;
            end else begin
              state_q <= ST_FILL_REQ;
            end
          end
        end
        ST_WB:       if (mem_gnt_i) state_q <= ST_FILL_REQ;
        ST_FILL_REQ: if (mem_gnt_i) state_q <= ST_FILL_WAIT;
        ST_FILL_WAIT: begin
          if (mem_rvalid_i) begin
            valid_q[cur_set][vway_q] <= 1'b1;
            dirty_q[cur_set][vway_q] <= cur_we && !WRITE_THROUGH;
            if (cur_we && WRITE_THROUGH) begin
              state_q <= ST_MEM_WR;
            end else begin
              state_q     <= ST_IDLE;
              rsp_valid_q <= 1'b1;
              rsp_rdata_q <= cur_we ? 32'd0 : rd_word;
            end
          end
        end
        ST_MEM_WR: begin
          if (mem_gnt_i) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  // memory port
  assign mem_req_o = (state_q == ST_WB) || (state_q == ST_FILL_REQ) || (state_q == ST_MEM_WR);
  assign mem_we_o  = (state_q == ST_WB) || (state_q == ST_MEM_WR);
  assign mem_addr_o = (state_q == ST_WB)
                    ? {tag_q[cur_set][vway_q], cur_set, {OFF_W{1'b0}}}
                    : {cur_addr[31:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata_o = (state_q == ST_WB) ? data_q[cur_set][vway_q] : {WORDS{cur_wdata}};
  assign mem_wstrb_o = (state_q == ST_WB) ? {LINE_BYTES{1'b1}} : word_strb;

  logic any_dirty;
  always_comb begin
    any_dirty = 1'b0;
    for (int s = 0; s < SETS; s++) any_dirty = any_dirty | (|dirty_q[s]);
  end

  // R9
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R7
  wt_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    WRITE_THROUGH |-> !any_dirty);

  // R4
  wb_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB) |-> (valid_q[cur_set][vway_q] && dirty_q[cur_set][vway_q]));

  // R3
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && req_valid_i) |-> $onehot0(match_vec));

  // R11
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && $stable(mem_wdata_o)));

endmodule

// File: tb/tb_sa_cache.sv
`timescale 1ns/1ps

module tb_line_mem #(
  parameter int LB = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [31:0]     addr_i,
  input  logic [LB*8-1:0] wdata_i,
  input  logic [LB-1:0]   wstrb_i,
  output logic            gnt_o,
  output logic            rvalid_o,
  output logic [LB*8-1:0] rdata_o,
  output int              rd_cnt_o,
  output int              wr_cnt_o
);
  logic [LB*8-1:0] m [64];

  initial begin
    for (int i = 0; i < 64; i++)
      for (int w = 0; w < LB/4; w++)
        m[i][w*32 +: 32] = 32'hC0DE_0000 ^ (i * 32'h0101_0100) ^ w;
  end

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_o <= 1'b0; rvalid_o <= 1'b0; rdata_o <= '0;
      rd_cnt_o <= 0; wr_cnt_o <= 0;
    end else begin
      gnt_o    <= req_i && !gnt_o;
      rvalid_o <= gnt_o && !we_i;
      if (gnt_o && !we_i) begin
        rdata_o  <= m[addr_i[9:4]];
        rd_cnt_o <= rd_cnt_o + 1;
      end
      if (gnt_o && we_i) wr_cnt_o <= wr_cnt_o + 1;
    end
  end

  always @(posedge clk_i) begin
    if (rst_ni && gnt_o && we_i)
      for (int b = 0; b < LB; b++)
        if (wstrb_i[b]) m[addr_i[9:4]][b*8 +: 8] <= wdata_i[b*8 +: 8];
  end
endmodule

module tb_sa_cache;
  localparam int LB = 16;
  localparam int LW = LB * 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        r_we = 0;
  logic [31:0] r_addr = 0, r_wd = 0;
  logic [3:0]  r_be = 0;
  logic        va = 0, vb = 0, fa = 0, fb = 0;

  logic rdy_a, rdy_b, rv_a, rv_b;
  logic [31:0] rd_a, rd_b;
  logic mreq_a, mreq_b, mwe_a, mwe_b, gnt_a, gnt_b, mrv_a, mrv_b;
  logic [31:0] maddr_a, maddr_b;
  logic [LW-1:0] mwd_a, mwd_b, mrd_a, mrd_b;
  logic [LB-1:0] mst_a, mst_b;
  int rc_a, rc_b, wc_a, wc_b;

  sa_cache #(.LINES(16), .WAYS(4), .LINE_BYTES(LB), .WRITE_THROUGH(1'b0), .WRITE_ALLOC(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(fa), .req_valid_i(va), .req_we_i(r_we),
    .req_addr_i(r_addr), .req_wdata_i(r_wd), .req_be_i(r_be), .req_ready_o(rdy_a),
    .rsp_valid_o(rv_a), .rsp_rdata_o(rd_a), .mem_req_o(mreq_a), .mem_we_o(mwe_a),
    .mem_addr_o(maddr_a), .mem_wdata_o(mwd_a), .mem_wstrb_o(mst_a), .mem_gnt_i(gnt_a),
    .mem_rvalid_i(mrv_a), .mem_rdata_i(mrd_a));

  sa_cache #(.LINES(16), .WAYS(4), .LINE_BYTES(LB), .WRITE_THROUGH(1'b1), .WRITE_ALLOC(1'b0)) dut_wt (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(fb), .req_valid_i(vb), .req_we_i(r_we),
    .req_addr_i(r_addr), .req_wdata_i(r_wd), .req_be_i(r_be), .req_ready_o(rdy_b),
    .rsp_valid_o(rv_b), .rsp_rdata_o(rd_b), .mem_req_o(mreq_b), .mem_we_o(mwe_b),
    .mem_addr_o(maddr_b), .mem_wdata_o(mwd_b), .mem_wstrb_o(mst_b), .mem_gnt_i(gnt_b),
    .mem_rvalid_i(mrv_b), .mem_rdata_i(mrd_b));

  tb_line_mem #(.LB(LB)) mem_a (.clk_i(clk), .rst_ni(rst_n), .req_i(mreq_a), .we_i(mwe_a),
    .addr_i(maddr_a), .wdata_i(mwd_a), .wstrb_i(mst_a), .gnt_o(gnt_a), .rvalid_o(mrv_a),
    .rdata_o(mrd_a), .rd_cnt_o(rc_a), .wr_cnt_o(wc_a));
  tb_line_mem #(.LB(LB)) mem_b (.clk_i(clk), .rst_ni(rst_n), .req_i(mreq_b), .we_i(mwe_b),
    .addr_i(maddr_b), .wdata_i(mwd_b), .wstrb_i(mst_b), .gnt_o(gnt_b), .rvalid_o(mrv_b),
    .rdata_o(mrd_b), .rd_cnt_o(rc_b), .wr_cnt_o(wc_b));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench model, index 0 = write-back/allocate, 1 = write-through/no-allocate
  bit          mv [2][4][4];
  bit          md [2][4][4];
  logic [31:0] mt [2][4][4];
  logic [LW-1:0] cd [2][4][4];
  int          rr [2][4];
  logic [LW-1:0] mimg [2][64];

  function automatic logic [LW-1:0] init_line(input int i);
    logic [LW-1:0] l;
    for (int w = 0; w < LB/4; w++) l[w*32 +: 32] = 32'hC0DE_0000 ^ (i * 32'h0101_0100) ^ w;
    return l;
  endfunction

  function automatic logic [LW-1:0] mline(input logic [LW-1:0] l, input int ws,
                                           input logic [31:0] wd, input logic [3:0] be);
    for (int b = 0; b < 4; b++) if (be[b]) l[ws*32 + b*8 +: 8] = wd[b*8 +: 8];
    return l;
  endfunction

  // R11: held memory request keeps its address
  logic pr_a = 0, pg_a = 0, pr_b = 0, pg_b = 0;
  logic [31:0] pa_a = 0, pa_b = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pr_a && !pg_a) chk(mreq_a && maddr_a == pa_a, "R11", maddr_a, pa_a);
      if (pr_b && !pg_b) chk(mreq_b && maddr_b == pa_b, "R11", maddr_b, pa_b);
    end
    pr_a = mreq_a; pg_a = gnt_a; pa_a = maddr_a;
    pr_b = mreq_b; pg_b = gnt_b; pa_b = maddr_b;
  end

  task automatic do_req(input int s, input bit we, input logic [31:0] a,
                        input logic [31:0] wd, input logic [3:0] be);
    int ln = a[9:4], st = a[5:4], ws = a[3:2], hw = -1, v, vl, erd = 0, ewr = 0, cyc, n;
    logic [31:0] tg = a >> 6, exp_d = 0;
    bit wt = (s == 1), wa = (s == 0);
    string tag;
    int rd0 = s ? rc_b : rc_a, wr0 = s ? wc_b : wc_a;
    for (int w = 0; w < 4; w++) if (mv[s][st][w] && mt[s][st][w] == tg) hw = w;
    if (hw >= 0) begin
      if (!we) begin
        tag = "R3"; exp_d = cd[s][st][hw][ws*32 +: 32];
      end else begin
        cd[s][st][hw] = mline(cd[s][st][hw], ws, wd, be);
        if (wt) begin tag = "R7"; ewr = 1; mimg[s][ln] = mline(mimg[s][ln], ws, wd, be); end
        else begin tag = "R6"; md[s][st][hw] = 1; end
      end
    end else if (we && !wa) begin
      tag = "R8"; ewr = 1; mimg[s][ln] = mline(mimg[s][ln], ws, wd, be);
    end else begin
      tag = we ? "R8" : "R4";
      v = -1;
      for (int w = 3; w >= 0; w--) if (!mv[s][st][w]) v = w;
      if (v < 0) begin v = rr[s][st]; rr[s][st] = (rr[s][st] + 1) % 4; tag = "R5"; end
      if (mv[s][st][v] && md[s][st][v]) begin
        ewr++; vl = ((mt[s][st][v] << 2) | st) & 63; mimg[s][vl] = cd[s][st][v];
      end
      erd = 1;
      cd[s][st][v] = mimg[s][ln]; mt[s][st][v] = tg; mv[s][st][v] = 1; md[s][st][v] = 0;
      if (we) begin
        cd[s][st][v] = mline(cd[s][st][v], ws, wd, be);
        if (wt) begin ewr++; mimg[s][ln] = mline(mimg[s][ln], ws, wd, be); end
        else md[s][st][v] = 1;
      end else exp_d = cd[s][st][v][ws*32 +: 32];
    end

    @(negedge clk);
    r_we = we; r_addr = a; r_wd = wd; r_be = be;
    if (s == 1) vb = 1; else va = 1;
    n = 0;
    while (!(s ? rdy_b : rdy_a) && n < 1000) begin @(negedge clk); n++; end
    @(negedge clk);
    va = 0; vb = 0;
    cyc = 1;
    while (!(s ? rv_b : rv_a) && cyc < 2000) begin
      chk(!(s ? rdy_b : rdy_a), "R9", 1, 0);
      @(negedge clk); cyc++;
    end
    chk(s ? rv_b : rv_a, "R9", 0, 1);
    chk(!(s ? rdy_b : rdy_a), "R9", 1, 0);
    if (hw >= 0 && !we) chk(cyc == 1, "R3", cyc, 1);
    if (!we) chk((s ? rd_b : rd_a) == exp_d, tag, s ? rd_b : rd_a, exp_d);
    chk((s ? rc_b : rc_a) - rd0 == erd, tag, (s ? rc_b : rc_a) - rd0, erd);
    chk((s ? wc_b : wc_a) - wr0 == ewr, tag, (s ? wc_b : wc_a) - wr0, ewr);
    @(negedge clk);
    chk(!(s ? rv_b : rv_a) && (s ? rdy_b : rdy_a), "R9", s ? rv_b : rv_a, 0);
  endtask

  task automatic do_flush(input int s);
    @(negedge clk);
    if (s == 1) fb = 1; else fa = 1;
    #1;
    chk(!(s ? rdy_b : rdy_a), "R10", 1, 0);
    @(negedge clk);
    fa = 0; fb = 0;
    for (int i = 0; i < 4; i++) for (int w = 0; w < 4; w++) begin
      mv[s][i][w] = 0; md[s][i][w] = 0;
    end
  endtask

  initial begin
    #(8 * 190000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C4C));
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 64; i++) mimg[s][i] = init_line(i);
      for (int i = 0; i < 4; i++) begin
        rr[s][i] = 0;
        for (int w = 0; w < 4; w++) begin mv[s][i][w] = 0; md[s][i][w] = 0; mt[s][i][w] = 0; end
      end
    end

    // R1
    chk(cache_pkg::off_bits(16) == 4, "R1", cache_pkg::off_bits(16), 4);
    chk(cache_pkg::idx_bits(2048, 4) == 9, "R1", cache_pkg::idx_bits(2048, 4), 9);
    chk(cache_pkg::tag_bits(32, 2048, 4, 16) == 19, "R1", cache_pkg::tag_bits(32, 2048, 4, 16), 19);
    chk(cache_pkg::idx_bits(512, 1) == 9, "R1", cache_pkg::idx_bits(512, 1), 9);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2
    chk(rdy_a && rdy_b, "R2", {rdy_a, rdy_b}, 2'b11);
    chk(!rv_a && !rv_b, "R2", {rv_a, rv_b}, 0);
    chk(!mreq_a && !mreq_b, "R2", {mreq_a, mreq_b}, 0);

    // directed, write-back instance: fill set 1, dirty a way, rotate victims
    do_req(0, 0, 32'h010, 0, 0);
    do_req(0, 0, 32'h050, 0, 0);
    do_req(0, 0, 32'h090, 0, 0);
    do_req(0, 0, 32'h0D0, 0, 0);
    do_req(0, 0, 32'h014, 0, 0);
    do_req(0, 1, 32'h058, 32'hDEAD_BEEF, 4'b0101);
    do_req(0, 0, 32'h058, 0, 0);
    do_req(0, 0, 32'h110, 0, 0);
    do_req(0, 0, 32'h150, 0, 0);
    do_req(0, 0, 32'h058, 0, 0);
    do_req(0, 0, 32'h8000_0010, 0, 0);
    do_req(0, 1, 32'h1A0, 32'h1234_5678, 4'b1111);
    do_flush(0);
    do_req(0, 0, 32'h1A0, 0, 0);

    // directed, write-through / no-allocate instance
    do_req(1, 1, 32'h024, 32'hA5A5_A5A5, 4'b0011);
    do_req(1, 0, 32'h024, 0, 0);
    do_req(1, 1, 32'h028, 32'h0BAD_F00D, 4'b1000);
    do_req(1, 0, 32'h028, 0, 0);
    do_flush(1);
    do_req(1, 0, 32'h028, 0, 0);

    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 400; k++) begin
        logic [31:0] a;
        a = {22'd0, 6'($urandom % 64), 2'($urandom % 4), 2'b00};
        if ($urandom % 8 == 0) a[31] = 1'b1;
        if ($urandom % 50 == 0) do_flush(s);
        do_req(s, 1'($urandom % 2), a, $urandom, 4'($urandom % 16));
      end
    end

    // memory contents vs model
    for (int i = 0; i < 64; i++) begin
      chk(mem_a.m[i] == mimg[0][i], "R4", mem_a.m[i], mimg[0][i]);
      chk(mem_b.m[i] == mimg[1][i], "R7", mem_b.m[i], mimg[1][i]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule